// File: doc/BRIEF.md
# Serial Peripheral Master Timing Engine

This block drives one serial peripheral as an SPI master, clocked by the master clock. Each word is requested through a start/ready handshake with parallel transmit data. The engine then lowers chip select and waits a programmable lead time. It shifts the word out on MOSI, most significant bit first, while it collects the reply from MISO. When the word ends it returns the received word in parallel with a one-cycle valid strobe.

Four settings are sampled whenever a word is accepted: a clock divisor, a lead delay, a gap count and a word-length code. The gap count, scaled by 32, sets an idle stretch after each word. At the end of that stretch the engine can start the next word without releasing chip select, provided a hold request is present and a new start is waiting. An illegal divisor or a reserved length code rejects the request and raises an error pulse.

Top module: `spi_xfer_timer`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, ready is 1, and err and rx_valid are 0.
- R2: A divisor d makes one sck period last d master cycles. The high phase is floor(d/2) cycles and the low phase is the remainder. A divisor of 1 runs as 2.
- R3: A start accepted while the divisor is 0 begins no word. err is 1 for exactly the cycle after acceptance, cs_n stays 1, and ready stays 1.
- R4: Length code c from 0 to 8 selects c+8 bits per word. Codes 9 to 15 are rejected in the same way as R3.
- R5: With a non-zero lead delay p, the first rising edge of sck comes p master cycles after cs_n falls.
- R6: With a lead delay of 0, the first rising edge comes after the low phase of the sck period, which is d - floor(d/2) cycles.
- R7: Bits are sent MSB first, and MOSI changes only while sck is low. MISO is sampled at each rising edge. rx_data is right-aligned with zeros above the word, and rx_valid pulses for one cycle at the last falling edge.
- R8: Let g be the gap count. When a chained word follows with gap g, its first rising edge comes 32*g plus the low phase after the previous word's last falling edge.
- R9: With g = 0, keep_cs high and start waiting, the next word follows with no break in the sck duty cycle, and cs_n stays 0.
- R10: If keep_cs is low or no start is waiting when the gap ends, cs_n rises 32*g cycles after the last falling edge, and ready is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Word request |
| ready | output | 1 | Request is taken this cycle if start is high |
| tx_data | input | 16 | Word to send, right-aligned |
| keep_cs | input | 1 | Hold chip select into a waiting next word |
| divisor | input | 8 | Master cycles per sck period (0 illegal) |
| lead_dly | input | 8 | Cycles from chip select to first sck edge (0 selects half period) |
| gap_dly | input | 8 | Inter-word gap in units of 32 cycles |
| width_code | input | 4 | Bits per word minus 8 (9 to 15 reserved) |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | rx_data updated this cycle |
| err | output | 1 | Request rejected |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench samples at the falling edge of the master clock and tracks every output in cycles counted from that edge. err is due one cycle after a rejected request is accepted, and the first sck rise is due lead cycles after cs_n falls. The phase lengths follow from the divisor. The next rise after a word, or the chip-select release, is due 32*g cycles after the last fall, plus the low phase when a word follows. The sampler takes time stamps for each of these, and each is compared against the value that the stated formula gives. Received words and the bits seen on MOSI are checked through a queue, which the monitor reads at each rx_valid.

// File: rtl/spi_xfer_timer.sv
module spi_xfer_timer #(
  parameter int DIVW = 8,
  parameter int DLYW = 8,
  parameter int GAP_SCALE = 32,
  parameter int WMAX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            ready,
  input  logic [WMAX-1:0] tx_data,
  input  logic            keep_cs,
  input  logic [DIVW-1:0] divisor,
  input  logic [DLYW-1:0] lead_dly,
  input  logic [DLYW-1:0] gap_dly,
  input  logic [3:0]      width_code,
  output logic [WMAX-1:0] rx_data,
  output logic            rx_valid,
  output logic            err,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n
);
  localparam int CW = $clog2(GAP_SCALE * (2 ** DLYW)) + 1;
  localparam int LW = $clog2(WMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_GAP} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [DIVW-1:0] div_q;
  logic [DLYW-1:0] gap_q;
  logic [LW-1:0]   left;
  logic [WMAX-1:0] sh, rsh;

  function automatic logic [DIVW-1:0] lo_of(input logic [DIVW-1:0] d);
    logic [DIVW-1:0] e;
    e = (d < DIVW'(2)) ? DIVW'(2) : d;
    return e - (e >> 1);
  endfunction

  wire [DIVW-1:0] eff   = (div_q < DIVW'(2)) ? DIVW'(2) : div_q;
  wire [DIVW-1:0] hi_n  = eff >> 1;
  wire [DIVW-1:0] lo_n  = eff - hi_n;
  wire last_fall = (st == S_HIGH) && (cnt == '0) && (left == LW'(1));
  wire bound     = (last_fall && gap_q == '0) || (st == S_GAP && cnt == '0);
  wire legal     = (divisor != '0) && (width_code <= 4'd8);
  wire take      = start && ready;
  wire go        = take && legal;

  assign ready = (st == S_IDLE) || (bound && keep_cs);
  assign mosi  = sh[WMAX-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  div_q <= '0;  gap_q <= '0;  left <= '0;
      sh <= '0;  rsh <= '0;  rx_data <= '0;  rx_valid <= 1'b0;  err <= 1'b0;
      sck <= 1'b0;  cs_n <= 1'b1;
    end else begin
      err      <= take && !legal;
      rx_valid <= 1'b0;
      case (st)
        S_LEAD, S_LOW:
          if (cnt == '0) begin
            sck <= 1'b1;
            rsh <= {rsh[WMAX-2:0], miso};
            cnt <= CW'(hi_n) - CW'(1);
            st  <= S_HIGH;
          end else cnt <= cnt - CW'(1);
        S_HIGH:
          if (cnt == '0) begin
            sck  <= 1'b0;
            left <= left - LW'(1);
            if (left == LW'(1)) begin
              rx_data  <= rsh;
              rx_valid <= 1'b1;
              if (gap_q != '0) begin
                st  <= S_GAP;
                cnt <= CW'(GAP_SCALE) * CW'(gap_q) - CW'(1);
              end else begin
                cs_n <= 1'b1;
                st   <= S_IDLE;
              end
            end else begin
              sh  <= sh << 1;
              cnt <= CW'(lo_n) - CW'(1);
              st  <= S_LOW;
            end
          end else cnt <= cnt - CW'(1);
        S_GAP:
          if (cnt == '0) begin
            cs_n <= 1'b1;
            st   <= S_IDLE;
          end else cnt <= cnt - CW'(1);
        default: ;
      endcase
      if (go) begin
        div_q <= divisor;
        gap_q <= gap_dly;
        left  <= LW'(width_code) + LW'(8);
        sh    <= tx_data << (4'd8 - width_code);
        rsh   <= '0;
        cs_n  <= 1'b0;
        if (st == S_IDLE) begin
          st  <= S_LEAD;
          cnt <= (lead_dly != '0) ? CW'(lead_dly) - CW'(1) : CW'(lo_of(divisor)) - CW'(1);
        end else begin
          st  <= S_LOW;
          cnt <= CW'(lo_of(divisor)) - CW'(1);
        end
      end
    end
  end

  p_sck_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_valid_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(sck));
  p_err_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start));
  p_bad_div_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && divisor == '0) |=> (cs_n && err && st == S_IDLE));
  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && width_code > 4'd8) |=> (err && cs_n));
  p_release_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ready);
endmodule

// File: tb/spi_xfer_timer_bench.sv
module spi_xfer_timer_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, start = 0, keep_cs = 0, miso;
  logic [15:0] tx_data = 0, rx_data;
  logic [7:0] divisor = 0, lead_dly = 0, gap_dly = 0;
  logic [3:0] width_code = 0;
  logic ready, rx_valid, err, sck, mosi, cs_n;

  spi_xfer_timer u_spi_xfer_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .tx_data(tx_data),
    .keep_cs(keep_cs), .divisor(divisor), .lead_dly(lead_dly), .gap_dly(gap_dly),
    .width_code(width_code), .rx_data(rx_data), .rx_valid(rx_valid), .err(err),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int n; logic [15:0] tx; logic [15:0] rx; } item_t;
  item_t q[$];
  int errors = 0, checks = 0;

  bit sbuf [0:1023];
  bit mbuf [0:1023];
  int swp = 0, srp = 0, mwp = 0, mrp = 0;
  assign miso = sbuf[srp];

  always @(posedge sck) begin
    mbuf[mwp] = mosi;
    mwp = mwp + 1;
    srp = srp + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0, t_cs = 0, t_rise = 0, t_fall = 0, t_last = 0;
  int lead = -1, hi_len = -1, lo_len = -1, cont = -1, rel = -1, cs_rises = 0;
  bit first_pend = 0, after_last = 0;
  logic p_sck = 0, p_cs = 1;

  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin
      t_last = cyc;
      after_last = 1;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R7: actual=unexpected word expected=none");
      end else begin
        item_t it;
        logic [15:0] m, got;
        it = q.pop_front();
        m = 16'((17'd1 << it.n) - 17'd1);
        got = 0;
        for (int i = 0; i < it.n; i++) begin
          got = {got[14:0], mbuf[mrp]};
          mrp++;
        end
        chk("R7 rx_data", int'(rx_data), int'(it.rx & m));
        chk("R7 mosi word", int'(got), int'(it.tx & m));
      end
    end
    if (p_cs && !cs_n) begin t_cs = cyc; first_pend = 1; end
    if (!p_cs && cs_n) begin cs_rises++; rel = cyc - t_last; after_last = 0; end
    if (!p_sck && sck) begin
      if (first_pend) begin lead = cyc - t_cs; first_pend = 0; end
      else lo_len = cyc - t_fall;
      if (after_last) begin cont = cyc - t_last; after_last = 0; end
      t_rise = cyc;
    end
    if (p_sck && !sck) begin hi_len = cyc - t_rise; t_fall = cyc; end
    p_sck = sck;
    p_cs = cs_n;
  end

  task automatic xfer(input logic [15:0] tx, input logic [3:0] code,
                      input logic [7:0] dv, input logic [7:0] pre,
                      input logic [7:0] gp, input logic keep);
    bit was;
    item_t it;
    divisor = dv; lead_dly = pre; gap_dly = gp; width_code = code; keep_cs = keep;
    tx_data = tx;
    if (dv != 0 && code <= 8) begin
      it.n = int'(code) + 8;
      it.tx = tx;
      it.rx = ~tx ^ 16'h5A3C;
      q.push_back(it);
      for (int i = it.n - 1; i >= 0; i--) begin
        sbuf[swp] = it.rx[i];
        swp++;
      end
    end
    start = 1;
    do begin
      was = ready;
      @(negedge clk);
    end while (!was);
    start = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(cs_n && q.size() == 0));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rs;
    repeat (3) @(negedge clk);
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0); chk("R1 ready", ready, 1);
    chk("R1 err", err, 0); chk("R1 rx_valid", rx_valid, 0);
    rst_n = 1;
    @(negedge clk);

    xfer(16'h00A5, 4'd0, 8'd0, 8'd2, 8'd0, 1'b0);
    chk("R3 err", err, 1); chk("R3 cs_n", cs_n, 1); chk("R3 ready", ready, 1);
    @(negedge clk);
    chk("R3 err pulse", err, 0);

    xfer(16'h00A5, 4'd9, 8'd4, 8'd2, 8'd0, 1'b0);
    chk("R4 code9 err", err, 1); chk("R4 code9 cs_n", cs_n, 1);
    xfer(16'h00A5, 4'd15, 8'd4, 8'd2, 8'd0, 1'b0);
    chk("R4 code15 err", err, 1);
    @(negedge clk);

    xfer(16'h00C3, 4'd0, 8'd4, 8'd3, 8'd0, 1'b0);
    wait_idle();
    chk("R5 lead", lead, 3); chk("R2 high d4", hi_len, 2); chk("R2 low d4", lo_len, 2);
    chk("R10 release gap0", rel, 0); chk("R10 ready", ready, 1);

    xfer(16'hB26D, 4'd8, 8'd5, 8'd0, 8'd0, 1'b0);
    wait_idle();
    chk("R6 lead d5", lead, 3); chk("R2 high d5", hi_len, 2); chk("R2 low d5", lo_len, 3);

    xfer(16'h0F5A, 4'd4, 8'd1, 8'd0, 8'd0, 1'b0);
    wait_idle();
    chk("R6 lead d1", lead, 1); chk("R2 high d1", hi_len, 1); chk("R2 low d1", lo_len, 1);

    rs = cs_rises;
    xfer(16'h0091, 4'd0, 8'd4, 8'd2, 8'd0, 1'b1);
    xfer(16'h0037, 4'd1, 8'd4, 8'd2, 8'd0, 1'b1);
    wait_idle();
    chk("R9 continuous", cont, 2); chk("R9 cs held", cs_rises - rs, 1);

    rs = cs_rises;
    xfer(16'h1234, 4'd8, 8'd6, 8'd2, 8'd1, 1'b1);
    xfer(16'h8001, 4'd8, 8'd6, 8'd2, 8'd1, 1'b1);
    wait_idle();
    chk("R8 chained gap", cont, 35); chk("R8 cs held", cs_rises - rs, 1);
    chk("R8 final release", rel, 32);

    xfer(16'h00E7, 4'd0, 8'd4, 8'd1, 8'd2, 1'b0);
    wait_idle();
    chk("R10 release gap2", rel, 64); chk("R10 ready after", ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule